// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside a memory target and arbitrates exclusive read/write pairs. When an exclusive read is accepted, the block stores a reservation made of the requester ID, the start address, the beat size and the burst length. When a later exclusive write from that ID is accepted, the block decides whether it succeeds. It succeeds only if its shape matches the reservation and no other requester has written into the reserved bytes in between. On a failure the block withholds the memory write-enable, so the failed write never reaches storage.

The block only observes traffic and never stalls it. A read-accept event and a write-accept event each carry an ID, address, size code, length field and an exclusive flag. The two events may arrive in the same cycle. One cycle later the block presents the response code for each event, together with a per-event valid pulse and, for writes, the memory update enable. Response codes use the standard two-bit encoding. The block only ever produces OKAY (00) or EXOKAY (01). A fixed number of reservation slots is set by a parameter.

Top module: `excl_monitor`

## Requirements
- R1: Each accepted read or write event yields its response exactly one cycle later, with `rd_rsp_vld`/`wr_rsp_vld` high for that one cycle only. Codes are OKAY=2'b00 and EXOKAY=2'b01. `wr_mem_en` is high only in a cycle where `wr_rsp_vld` is high.
- R2: An exclusive request is well formed when its byte count, (len+1)·2^size, is a power of two no larger than 128 and its address is a multiple of that count. A well-formed exclusive read that obtains a slot answers EXOKAY and records a reservation. An ill-formed exclusive read answers OKAY and records nothing.
- R3: An exclusive read from an ID that already holds a slot replaces that slot's address and shape. If the ID holds no slot and every slot is taken by other IDs, the read answers OKAY and records nothing. A slot freed later can be taken again.
- R4: An exclusive write passes only if its ID holds a reservation with the identical address, size and length. A passing write gets EXOKAY and `wr_mem_en`=1. Any other exclusive write gets OKAY and `wr_mem_en`=0.
- R5: Every exclusive write, passing or failing, removes the writer's own reservation, so an immediate repeat of the same exclusive write fails.
- R6: A non-exclusive write from a different ID that overlaps any byte of a reservation removes that reservation. A write that only touches neighbouring bytes does not remove it, and neither does a write from the holder's own ID.
- R7: Non-exclusive reads and writes are never blocked. They always answer OKAY, every non-exclusive write gets `wr_mem_en`=1, and reads never remove reservations.
- R8: A passing exclusive write removes overlapping reservations held by other IDs. A failing exclusive write from another ID leaves them untouched.
- R9: When a read event and a write event fall in the same cycle, the write's effect on the slots is applied first and the read's reservation is installed afterwards. A reservation set up in that cycle therefore survives an overlapping write from another ID in that same cycle.
- R10: Reset (synchronous, active high) drops all reservations and holds both valid outputs and `wr_mem_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_evt | input | 1 | Read request accepted this cycle |
| rd_id | input | ID_W | Requester ID of the read |
| rd_addr | input | ADDR_W | Start byte address of the read |
| rd_size | input | 3 | Beat size code, bytes per beat = 2^code |
| rd_len | input | 8 | Beats minus one |
| rd_excl | input | 1 | Read is exclusive |
| wr_evt | input | 1 | Write request accepted this cycle |
| wr_id | input | ID_W | Requester ID of the write |
| wr_addr | input | ADDR_W | Start byte address of the write |
| wr_size | input | 3 | Beat size code |
| wr_len | input | 8 | Beats minus one |
| wr_excl | input | 1 | Write is exclusive |
| rd_rsp_vld | output | 1 | Read response code is valid |
| rd_rsp | output | 2 | Read response code |
| wr_rsp_vld | output | 1 | Write response code is valid |
| wr_rsp | output | 2 | Write response code |
| wr_mem_en | output | 1 | Allow the memory to apply the write |

## Verification
The two functions that can coincide are reservation setup by an exclusive read and reservation removal by a write on the other port. They collide when both events arrive in one cycle against the same bytes. The bench provokes this by first giving an ID a reservation, then issuing in one cycle a fresh exclusive read from that ID together with an overlapping plain write from another ID. The outcome is judged by the read answer (EXOKAY), the write answer and enable (OKAY, 1), and a following exclusive write from the reserving ID, which must pass.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    // Response code values on the response outputs
    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_e;

    localparam int SIZE_W         = 3;
    localparam int LEN_W          = 8;
    localparam int BYTES_W        = 16;
    localparam int MAX_EXCL_BYTES = 128;

    // Shape of a burst: beat size code and beat count minus one
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [LEN_W-1:0]  len;
    } shape_t;

    // Total bytes moved by a burst
    function automatic logic [BYTES_W-1:0] burst_bytes(input shape_t s);
        logic [BYTES_W-1:0] beats;
        beats = BYTES_W'(s.len) + BYTES_W'(1);
        return beats << s.size;
    endfunction

    function automatic logic is_pow2(input logic [BYTES_W-1:0] v);
        return (v != '0) && ((v & (v - BYTES_W'(1))) == '0);
    endfunction

    // Exclusive legality: power-of-two total, at most 128 bytes, aligned start
    function automatic logic excl_legal(input logic [7:0] addr_lo, input shape_t s);
        logic [BYTES_W-1:0] n;
        n = burst_bytes(s);
        return is_pow2(n) && (n <= BYTES_W'(MAX_EXCL_BYTES))
               && ((BYTES_W'(addr_lo) & (n - BYTES_W'(1))) == '0);
    endfunction

endpackage

// File: rtl/excl_alloc.sv
module excl_alloc #(
    parameter int NUM = 4
) (
    input  logic [NUM-1:0] free_vec,
    output logic [NUM-1:0] pick,
    output logic           any_free
);
    // Lowest-index free slot wins
    always_comb begin
        pick = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                pick = '0;
                pick[i] = 1'b1;
            end
        end
    end

    assign any_free = |free_vec;

endmodule

// File: rtl/excl_entry.sv
module excl_entry
    import excl_mon_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [ID_W-1:0]   new_id,
    input  logic [ADDR_W-1:0] new_addr,
    input  shape_t            new_shape,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W:0]   wr_end,
    input  shape_t            wr_shape,
    output logic              vld,
    output logic              rd_own,
    output logic              wr_own,
    output logic              wr_exact,
    output logic              wr_foreign_hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic              vld_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    shape_t            shape_q;
    logic [EXT_W-1:0]  end_q;

    // A set in the same cycle as a clear wins: the read is ordered after the write
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            id_q    <= '0;
            addr_q  <= '0;
            shape_q <= '0;
            end_q   <= '0;
        end else if (set) begin
            vld_q   <= 1'b1;
            id_q    <= new_id;
            addr_q  <= new_addr;
            shape_q <= new_shape;
            end_q   <= {1'b0, new_addr} + EXT_W'(burst_bytes(new_shape));
        end else if (clr) begin
            vld_q   <= 1'b0;
        end
    end

    logic range_hit;
    assign range_hit = ({1'b0, addr_q} < wr_end) && ({1'b0, wr_addr} < end_q);

    assign vld            = vld_q;
    assign rd_own         = vld_q && (id_q == rd_id);
    assign wr_own         = vld_q && (id_q == wr_id);
    assign wr_exact       = wr_own && (addr_q == wr_addr) && (shape_q == wr_shape);
    assign wr_foreign_hit = vld_q && (id_q != wr_id) && range_hit;

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ID_W        = 4,
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_evt,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [2:0]        rd_size,
    input  logic [7:0]        rd_len,
    input  logic              rd_excl,
    input  logic              wr_evt,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2:0]        wr_size,
    input  logic [7:0]        wr_len,
    input  logic              wr_excl,
    output logic              rd_rsp_vld,
    output logic [1:0]        rd_rsp,
    output logic              wr_rsp_vld,
    output logic [1:0]        wr_rsp,
    output logic              wr_mem_en
);
    localparam int EXT_W = ADDR_W + 1;

    shape_t rd_shape, wr_shape;
    assign rd_shape = '{size: rd_size, len: rd_len};
    assign wr_shape = '{size: wr_size, len: wr_len};

    logic [EXT_W-1:0] wr_end;
    assign wr_end = {1'b0, wr_addr} + EXT_W'(burst_bytes(wr_shape));

    logic rd_ok, wr_ok;
    assign rd_ok = excl_legal(rd_addr[7:0], rd_shape);
    assign wr_ok = excl_legal(wr_addr[7:0], wr_shape);

    logic [NUM_ENTRIES-1:0] ent_vld, ent_rd_own, ent_wr_own, ent_exact, ent_foreign;
    logic [NUM_ENTRIES-1:0] ent_set, ent_clr, vld_after, rd_hit, pick;
    logic                   any_free;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_slot
            excl_entry #(
                .ID_W   (ID_W),
                .ADDR_W (ADDR_W)
            ) u_slot (
                .clk            (clk),
                .rst            (rst),
                .set            (ent_set[g]),
                .clr            (ent_clr[g]),
                .new_id         (rd_id),
                .new_addr       (rd_addr),
                .new_shape      (rd_shape),
                .rd_id          (rd_id),
                .wr_id          (wr_id),
                .wr_addr        (wr_addr),
                .wr_end         (wr_end),
                .wr_shape       (wr_shape),
                .vld            (ent_vld[g]),
                .rd_own         (ent_rd_own[g]),
                .wr_own         (ent_wr_own[g]),
                .wr_exact       (ent_exact[g]),
                .wr_foreign_hit (ent_foreign[g])
            );
        end
    endgenerate

    // Write side: pass decision and memory update
    logic wr_pass, mem_upd;
    assign wr_pass = wr_evt && wr_excl && wr_ok && (|ent_exact);
    assign mem_upd = wr_evt && (!wr_excl || wr_pass);

    // Slot removal: own slot on any exclusive write, foreign overlap on a real update
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            ent_clr[i] = wr_evt && ((wr_excl && ent_wr_own[i]) || (mem_upd && ent_foreign[i]));
        end
    end

    assign vld_after = ent_vld & ~ent_clr;
    assign rd_hit    = ent_rd_own & ~ent_clr;

    excl_alloc #(
        .NUM (NUM_ENTRIES)
    ) u_alloc (
        .free_vec (~vld_after),
        .pick     (pick),
        .any_free (any_free)
    );

    // Read side: reuse own slot first, else the lowest free slot
    logic rd_want, rd_grant;
    assign rd_want  = rd_evt && rd_excl && rd_ok;
    assign rd_grant = rd_want && ((|rd_hit) || any_free);

    always_comb begin
        ent_set = '0;
        if (rd_want) begin
            ent_set = (|rd_hit) ? rd_hit : pick;
        end
    end

    // Registered responses, one cycle after each event
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_rsp_vld <= 1'b0;
            rd_rsp     <= RSP_OKAY;
            wr_rsp_vld <= 1'b0;
            wr_rsp     <= RSP_OKAY;
            wr_mem_en  <= 1'b0;
        end else begin
            rd_rsp_vld <= rd_evt;
            rd_rsp     <= rd_grant ? RSP_EXOKAY : RSP_OKAY;
            wr_rsp_vld <= wr_evt;
            wr_rsp     <= wr_pass ? RSP_EXOKAY : RSP_OKAY;
            wr_mem_en  <= mem_upd;
        end
    end

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
    import excl_mon_pkg::*;
#(
    parameter int ID_W        = 4,
    parameter int ADDR_W      = 32,
    parameter int NUM_ENTRIES = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rd_evt,
    input logic [ADDR_W-1:0]      rd_addr,
    input logic [2:0]             rd_size,
    input logic [7:0]             rd_len,
    input logic                   rd_excl,
    input logic                   wr_evt,
    input logic                   wr_excl,
    input logic                   rd_rsp_vld,
    input logic [1:0]             rd_rsp,
    input logic                   wr_rsp_vld,
    input logic [1:0]             wr_rsp,
    input logic                   wr_mem_en,
    input logic [NUM_ENTRIES-1:0] ent_vld,
    input logic [NUM_ENTRIES-1:0] ent_rd_own
);
    // R1
    rd_rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_evt |=> rd_rsp_vld);
    // R1
    wr_rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_evt |=> !wr_rsp_vld && !wr_mem_en);
    // R1
    rsp_code_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rsp_vld |-> rd_rsp[1] == 1'b0) and (wr_rsp_vld |-> wr_rsp[1] == 1'b0));
    // R2
    bad_excl_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_evt && rd_excl && !excl_legal(rd_addr[7:0], '{size: rd_size, len: rd_len})
        |=> rd_rsp == RSP_OKAY);
    // R3
    one_slot_per_id_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ent_rd_own));
    // R4
    exok_writes_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rsp_vld && wr_rsp == RSP_EXOKAY |-> wr_mem_en);
    // R4
    fail_no_update_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt && wr_excl |=> (wr_rsp == RSP_OKAY) == !wr_mem_en);
    // R7
    plain_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_evt && !wr_excl |=> wr_mem_en && wr_rsp == RSP_OKAY);
    // R7
    plain_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_evt && !rd_excl |=> rd_rsp == RSP_OKAY);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ent_vld == '0 && !rd_rsp_vld && !wr_rsp_vld && !wr_mem_en);

endmodule

bind excl_monitor excl_monitor_chk #(
    .ID_W        (ID_W),
    .ADDR_W      (ADDR_W),
    .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_evt     (rd_evt),
    .rd_addr    (rd_addr),
    .rd_size    (rd_size),
    .rd_len     (rd_len),
    .rd_excl    (rd_excl),
    .wr_evt     (wr_evt),
    .wr_excl    (wr_excl),
    .rd_rsp_vld (rd_rsp_vld),
    .rd_rsp     (rd_rsp),
    .wr_rsp_vld (wr_rsp_vld),
    .wr_rsp     (wr_rsp),
    .wr_mem_en  (wr_mem_en),
    .ent_vld    (ent_vld),
    .ent_rd_own (ent_rd_own)
);

// File: tb/excl_monitor_tb.sv
`timescale 1ns/1ps
module excl_monitor_tb;

    localparam int ID_W = 4;
    localparam int AW   = 32;

    typedef struct packed {
        logic          rv;
        logic [3:0]    rid;
        logic [31:0]   raddr;
        logic [2:0]    rsz;
        logic [7:0]    rlen;
        logic          rx;
        logic          wv;
        logic [3:0]    wid;
        logic [31:0]   waddr;
        logic [2:0]    wsz;
        logic [7:0]    wlen;
        logic          wx;
        logic [1:0]    erd;
        logic [1:0]    ewr;
        logic          emen;
        logic [7:0]    tag;
    } vec_t;

    localparam logic [1:0] OK = 2'b00;
    localparam logic [1:0] EX = 2'b01;

    // Read-only vector
    function automatic vec_t rdv(input logic [3:0] id, input logic [31:0] a, input logic [2:0] sz,
                                 input logic [7:0] ln, input logic x, input logic [1:0] e, input int t);
        return '{rv: 1'b1, rid: id, raddr: a, rsz: sz, rlen: ln, rx: x,
                 wv: 1'b0, wid: '0, waddr: '0, wsz: '0, wlen: '0, wx: 1'b0,
                 erd: e, ewr: OK, emen: 1'b0, tag: 8'(t)};
    endfunction

    // Write-only vector
    function automatic vec_t wrv(input logic [3:0] id, input logic [31:0] a, input logic [2:0] sz,
                                 input logic [7:0] ln, input logic x, input logic [1:0] e,
                                 input logic m, input int t);
        return '{rv: 1'b0, rid: '0, raddr: '0, rsz: '0, rlen: '0, rx: 1'b0,
                 wv: 1'b1, wid: id, waddr: a, wsz: sz, wlen: ln, wx: x,
                 erd: OK, ewr: e, emen: m, tag: 8'(t)};
    endfunction

    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        rdv(4'd1, 32'h100, 3'd2, 8'd0,  1'b1, EX, 2),        // R2 4-byte reservation
        wrv(4'd1, 32'h100, 3'd2, 8'd0,  1'b1, EX, 1'b1, 4),  // R4 matching write passes
        wrv(4'd1, 32'h100, 3'd2, 8'd0,  1'b1, OK, 1'b0, 5),  // R5 repeat fails
        rdv(4'd1, 32'h100, 3'd2, 8'd3,  1'b1, EX, 2),        // R2 16 bytes aligned
        wrv(4'd1, 32'h100, 3'd2, 8'd1,  1'b1, OK, 1'b0, 4),  // R4 length mismatch
        wrv(4'd1, 32'h100, 3'd2, 8'd3,  1'b1, OK, 1'b0, 5),  // R5 cleared by failing write
        rdv(4'd2, 32'h102, 3'd2, 8'd0,  1'b1, OK, 2),        // R2 misaligned
        wrv(4'd2, 32'h102, 3'd2, 8'd0,  1'b1, OK, 1'b0, 2),  // R2 nothing was reserved
        rdv(4'd2, 32'h200, 3'd3, 8'd15, 1'b1, EX, 2),        // R2 128 bytes
        rdv(4'd3, 32'h000, 3'd4, 8'd15, 1'b1, OK, 2),        // R2 256 bytes too large
        rdv(4'd3, 32'h300, 3'd0, 8'd2,  1'b1, OK, 2),        // R2 3 bytes not power of two
        wrv(4'd4, 32'h27C, 3'd2, 8'd0,  1'b0, OK, 1'b1, 7),  // R7 plain write, hits id2 range
        wrv(4'd2, 32'h200, 3'd3, 8'd15, 1'b1, OK, 1'b0, 6),  // R6 removed by foreign write
        rdv(4'd5, 32'h400, 3'd2, 8'd0,  1'b1, EX, 2),
        wrv(4'd6, 32'h404, 3'd2, 8'd0,  1'b0, OK, 1'b1, 6),  // R6 adjacent bytes only
        wrv(4'd5, 32'h400, 3'd2, 8'd0,  1'b0, OK, 1'b1, 6),  // R6 own plain write
        rdv(4'd7, 32'h400, 3'd2, 8'd0,  1'b0, OK, 7),        // R7 plain read
        wrv(4'd5, 32'h400, 3'd2, 8'd0,  1'b1, EX, 1'b1, 6),  // R6 reservation survived
        rdv(4'd1, 32'h500, 3'd2, 8'd0,  1'b1, EX, 8),
        rdv(4'd2, 32'h500, 3'd2, 8'd0,  1'b1, EX, 8),
        wrv(4'd2, 32'h500, 3'd1, 8'd1,  1'b1, OK, 1'b0, 8),  // R8 foreign write fails
        rdv(4'd2, 32'h500, 3'd2, 8'd0,  1'b1, EX, 8),
        wrv(4'd1, 32'h500, 3'd2, 8'd0,  1'b1, EX, 1'b1, 8),  // R8 id1 kept its slot
        wrv(4'd2, 32'h500, 3'd2, 8'd0,  1'b1, OK, 1'b0, 8),  // R8 removed by id1 pass
        rdv(4'd3, 32'h600, 3'd2, 8'd0,  1'b1, EX, 9),
        '{rv: 1'b1, rid: 4'd3, raddr: 32'h600, rsz: 3'd2, rlen: 8'd0, rx: 1'b1,
          wv: 1'b1, wid: 4'd4, waddr: 32'h600, wsz: 3'd2, wlen: 8'd0, wx: 1'b0,
          erd: EX, ewr: OK, emen: 1'b1, tag: 8'd9},          // R9 same-cycle collision
        wrv(4'd3, 32'h600, 3'd2, 8'd0,  1'b1, EX, 1'b1, 9),  // R9 read installed last
        rdv(4'd8,  32'h700, 3'd2, 8'd0, 1'b1, EX, 3),
        rdv(4'd9,  32'h710, 3'd2, 8'd0, 1'b1, EX, 3),
        rdv(4'd10, 32'h720, 3'd2, 8'd0, 1'b1, EX, 3),
        rdv(4'd11, 32'h730, 3'd2, 8'd0, 1'b1, EX, 3),
        rdv(4'd12, 32'h740, 3'd2, 8'd0, 1'b1, OK, 3),        // R3 all slots taken
        rdv(4'd8,  32'h780, 3'd2, 8'd0, 1'b1, EX, 3),        // R3 own slot reused
        wrv(4'd8,  32'h700, 3'd2, 8'd0, 1'b1, OK, 1'b0, 3),  // R3 old address replaced
        rdv(4'd12, 32'h740, 3'd2, 8'd0, 1'b1, EX, 3),        // R3 freed slot taken
        wrv(4'd12, 32'h740, 3'd2, 8'd0, 1'b1, EX, 1'b1, 3)
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_evt = 1'b0, rd_excl = 1'b0, wr_evt = 1'b0, wr_excl = 1'b0;
    logic [ID_W-1:0]   rd_id = '0, wr_id = '0;
    logic [AW-1:0]     rd_addr = '0, wr_addr = '0;
    logic [2:0]        rd_size = '0, wr_size = '0;
    logic [7:0]        rd_len = '0, wr_len = '0;
    logic              rd_rsp_vld, wr_rsp_vld, wr_mem_en;
    logic [1:0]        rd_rsp, wr_rsp;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    excl_monitor #(.ID_W(ID_W), .ADDR_W(AW), .NUM_ENTRIES(4)) u_dut (
        .clk(clk), .rst(rst),
        .rd_evt(rd_evt), .rd_id(rd_id), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_len(rd_len), .rd_excl(rd_excl),
        .wr_evt(wr_evt), .wr_id(wr_id), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_len(wr_len), .wr_excl(wr_excl),
        .rd_rsp_vld(rd_rsp_vld), .rd_rsp(rd_rsp),
        .wr_rsp_vld(wr_rsp_vld), .wr_rsp(wr_rsp), .wr_mem_en(wr_mem_en)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        rd_evt = v.rv; rd_id = v.rid; rd_addr = v.raddr; rd_size = v.rsz; rd_len = v.rlen; rd_excl = v.rx;
        wr_evt = v.wv; wr_id = v.wid; wr_addr = v.waddr; wr_size = v.wsz; wr_len = v.wlen; wr_excl = v.wx;
    endtask

    // Drive at the falling edge, look 1 ns after the capturing rising edge
    task automatic step(input vec_t v);
        @(negedge clk);
        apply(v);
        @(posedge clk);
        #1;
    endtask

    task automatic idle_step();
        vec_t z;
        z = '0;
        step(z);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 outputs quiet in reset
        check(!rd_rsp_vld && !wr_rsp_vld && !wr_mem_en, "R10 reset outputs",
              {rd_rsp_vld, wr_rsp_vld, wr_mem_en}, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i]);
            check(rd_rsp_vld == TBL[i].rv && (!TBL[i].rv || rd_rsp == TBL[i].erd),
                  $sformatf("R%0d vec%0d read", TBL[i].tag, i),
                  {rd_rsp_vld, rd_rsp}, {TBL[i].rv, TBL[i].erd});
            check(wr_rsp_vld == TBL[i].wv &&
                  (!TBL[i].wv || (wr_rsp == TBL[i].ewr && wr_mem_en == TBL[i].emen)),
                  $sformatf("R%0d vec%0d write", TBL[i].tag, i),
                  {wr_rsp_vld, wr_rsp, wr_mem_en}, {TBL[i].wv, TBL[i].ewr, TBL[i].emen});
        end

        // R1 responses are single-cycle pulses
        idle_step();
        check(!rd_rsp_vld && !wr_rsp_vld && !wr_mem_en, "R1 pulse ends",
              {rd_rsp_vld, wr_rsp_vld, wr_mem_en}, 0);

        // R10 reset drops a live reservation
        step(rdv(4'd1, 32'h800, 3'd2, 8'd0, 1'b1, EX, 10));
        check(rd_rsp == EX, "R10 reserve before reset", rd_rsp, EX);
        @(negedge clk);
        apply('0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(!rd_rsp_vld && !wr_rsp_vld, "R10 valid low in reset", {rd_rsp_vld, wr_rsp_vld}, 0);
        @(negedge clk);
        rst = 1'b0;
        step(wrv(4'd1, 32'h800, 3'd2, 8'd0, 1'b1, OK, 1'b0, 10));
        check(wr_rsp == OK && !wr_mem_en, "R10 reservation gone", {wr_rsp, wr_mem_en}, {OK, 1'b0});

        idle_step();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule